// File: doc/BRIEF.md
# ISA Host Cycle Address Decoder

This block sits behind the ISA bus pins of a 16-bit peripheral. It turns raw host cycles into clean internal register accesses. It has two independent decode paths.

The I/O path is always live. It claims a 16-byte block of host I/O space that holds eight 16-bit ports, and it accepts a cycle only while AEN is low. The memory path claims a 4-Kbyte window of host memory, and only while a software-controlled enable input is set.

The active-low command lines are synchronised to the internal clock. Each falling command edge that hits one of the windows becomes a single-clock read or write strobe. The strobe carries a port index, a byte-lane bit and a 12-bit window offset. A small register-file stub behind the decoder stores write data and returns read data, so that the complete access path can be exercised.

Top module: `isa_slave_decoder`

## Requirements
- R1: An I/O read is a falling edge on `ior_n` while `aen` is 0 and `sa[15:4]` equals `io_base[15:4]`. It produces exactly one `rd_stb` pulse SYNC_STAGES+1 clocks after the edge, with `is_mem`=0, `port_idx`=`sa[3:1]` and `byte_lane`=`sa[0]`.
- R2: An I/O write is a falling edge on `iow_n` under the same match conditions as R1. It produces one `wr_stb` pulse with the same latency and the same field mapping, and it stores `wr_data` into port `sa[3:1]` of the stub.
- R3: When `aen` is 1, no I/O command produces a strobe.
- R4: An I/O address whose `sa[15:4]` differs from `io_base[15:4]` produces no strobe. Bits `io_base[3:0]` have no effect on the decode.
- R5: The I/O path decodes from reset onward, whatever the value of `mem_en`.
- R6: With `mem_en`=1, a falling edge on `memr_n` or `memw_n` whose `sa[ADDR_W-1:12]` equals `mem_base[ADDR_W-1:12]` gives one `rd_stb` or `wr_stb` pulse with `is_mem`=1 and `mem_off`=`sa[11:0]`. AEN has no part in this decode.
- R7: With `mem_en`=0, memory commands produce no strobe.
- R8: When both commands of a pair are low together on a hit (`ior_n`/`iow_n` or `memr_n`/`memw_n`), that pair produces no strobe. `cmd_err` instead pulses for one clock, at the latency a strobe would have had.
- R9: Each strobe lasts one clock. Holding a command low produces no further strobes.
- R10: After reset, `rd_stb`, `wr_stb`, `is_mem`, `cmd_err`, `port_idx`, `mem_off` and `rd_data` are all 0.
- R11: After a read strobe, `rd_data` holds the value most recently written to the same I/O port, or to the same stub memory word. The memory word index is `mem_off[4:1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aen | input | 1 | Address enable; high marks a DMA cycle |
| sa | input | ADDR_W | Host system address |
| ior_n | input | 1 | I/O read command, active low |
| iow_n | input | 1 | I/O write command, active low |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| mem_en | input | 1 | Enables the memory window |
| io_base | input | 16 | I/O window base; low 4 bits ignored |
| mem_base | input | ADDR_W | Memory window base; low 12 bits ignored |
| wr_data | input | 16 | Host write data |
| rd_stb | output | 1 | One-clock read strobe |
| wr_stb | output | 1 | One-clock write strobe |
| is_mem | output | 1 | Strobe belongs to the memory window |
| port_idx | output | 3 | I/O port index |
| byte_lane | output | 1 | Byte-lane select of the access |
| mem_off | output | 12 | Offset of the access in its window |
| cmd_err | output | 1 | One-clock pulse on a conflicting command pair |
| rd_data | output | 16 | Read data captured from the stub |

## Verification
The bench builds the decoder with its defaults: a 20-bit address, two synchroniser stages, and a 16-word memory stub. This makes the strobe latency exactly three clocks. It also makes the memory window decode on address bits 19:12, so upper-bit mismatches in both windows can be reached with random addresses. The I/O base is deliberately given nonzero low bits, to show that they are ignored. Random addresses are biased towards both windows, and they are mixed with directed conflict cases and with long command holds.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int unsigned NCMD     = 4;
  localparam int unsigned C_IOR    = 0;
  localparam int unsigned C_IOW    = 1;
  localparam int unsigned C_MEMR   = 2;
  localparam int unsigned C_MEMW   = 3;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned OFF_W    = 12;
  localparam int unsigned IO_AW    = 16;
  localparam int unsigned NPORTS   = 8;
  localparam int unsigned PORT_W   = $clog2(NPORTS);

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              mem;
    logic              err;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] data;
  } acc_t;
endpackage

// File: rtl/isa_cmd_sync.sv
module isa_cmd_sync #(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cmd_n_i,
  output logic [WIDTH-1:0] lvl_n_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stg_q [SYNC_STAGES];
  logic [WIDTH-1:0] stg_d [SYNC_STAGES];
  logic [WIDTH-1:0] prev_q, prev_d;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = cmd_n_i;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '1;
        else         stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  always_comb prev_d = stg_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= prev_d;
  end

  always_comb begin
    lvl_n_o = stg_q[SYNC_STAGES-1];
    fall_o  = prev_q & ~stg_q[SYNC_STAGES-1];
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      assert_single_fall_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        fall_o[i] |=> !fall_o[i]);
    end
  endgenerate
endmodule

// File: rtl/isa_win_match.sv
module isa_win_match
  import isa_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              aen_i,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic              mem_en_i,
  input  logic [IO_AW-1:0]  io_base_i,
  input  logic [ADDR_W-1:0] mem_base_i,
  output logic              io_hit_o,
  output logic              mem_hit_o
);
  localparam int unsigned IO_LSB  = 4;
  localparam int unsigned MEM_LSB = OFF_W;

  logic io_tag_eq, mem_tag_eq;

  always_comb begin
    io_tag_eq  = (sa_i[IO_AW-1:IO_LSB] == io_base_i[IO_AW-1:IO_LSB]);
    mem_tag_eq = (sa_i[ADDR_W-1:MEM_LSB] == mem_base_i[ADDR_W-1:MEM_LSB]);
    io_hit_o   = io_tag_eq & ~aen_i;
    mem_hit_o  = mem_tag_eq & mem_en_i;
  end
endmodule

// File: rtl/isa_acc_ctl.sv
module isa_acc_ctl
  import isa_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [NCMD-1:0]   lvl_n_i,
  input  logic [NCMD-1:0]   fall_i,
  input  logic              io_hit_i,
  input  logic              mem_hit_i,
  input  logic [ADDR_W-1:0] sa_i,
  input  logic [DATA_W-1:0] wdata_i,
  output acc_t              acc_o
);
  logic io_conf, mem_conf;
  logic io_conf_q, mem_conf_q;
  logic io_rd, io_wr, mem_rd, mem_wr, any_io;
  logic err_d, load_en;
  acc_t acc_q, acc_d;

  always_comb begin
    io_conf  = ~lvl_n_i[C_IOR]  & ~lvl_n_i[C_IOW];
    mem_conf = ~lvl_n_i[C_MEMR] & ~lvl_n_i[C_MEMW];
    err_d    = (io_conf & ~io_conf_q & io_hit_i) |
               (mem_conf & ~mem_conf_q & mem_hit_i);
    io_rd    = fall_i[C_IOR]  & ~io_conf  & io_hit_i  & ~err_d;
    io_wr    = fall_i[C_IOW]  & ~io_conf  & io_hit_i  & ~err_d;
    any_io   = io_rd | io_wr;
    mem_rd   = fall_i[C_MEMR] & ~mem_conf & mem_hit_i & ~err_d & ~any_io;
    mem_wr   = fall_i[C_MEMW] & ~mem_conf & mem_hit_i & ~err_d & ~any_io;
    load_en  = any_io | mem_rd | mem_wr;
  end

  always_comb begin
    acc_d      = acc_q;
    acc_d.rd   = io_rd | mem_rd;
    acc_d.wr   = io_wr | mem_wr;
    acc_d.err  = err_d;
    if (load_en) begin
      acc_d.mem  = mem_rd | mem_wr;
      acc_d.off  = sa_i[OFF_W-1:0];
      acc_d.data = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      io_conf_q  <= 1'b0;
      mem_conf_q <= 1'b0;
    end else begin
      acc_q      <= acc_d;
      io_conf_q  <= io_conf;
      mem_conf_q <= mem_conf;
    end
  end

  always_comb acc_o = acc_q;

  assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(acc_q.rd && acc_q.wr));
  assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_q.err |-> !(acc_q.rd || acc_q.wr));
  assert_stb_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_q.rd || acc_q.wr) |=> !(acc_q.rd || acc_q.wr));
endmodule

// File: rtl/isa_reg_stub.sv
module isa_reg_stub
  import isa_dec_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  acc_t              acc_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned MW_BITS = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] port_q [NPORTS];
  logic [DATA_W-1:0] mem_q  [MEM_WORDS];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [PORT_W-1:0] pidx;
  logic [MW_BITS-1:0] midx;

  always_comb begin
    pidx = acc_i.off[PORT_W:1];
    midx = acc_i.off[MW_BITS:1];
  end

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic we;
      always_comb we = acc_i.wr & ~acc_i.mem & (pidx == PORT_W'(p));
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)  port_q[p] <= '0;
        else if (we)  port_q[p] <= acc_i.data;
      end
    end
    for (genvar w = 0; w < MEM_WORDS; w++) begin : g_word
      logic we;
      always_comb we = acc_i.wr & acc_i.mem & (midx == MW_BITS'(w));
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)  mem_q[w] <= '0;
        else if (we)  mem_q[w] <= acc_i.data;
      end
    end
  endgenerate

  always_comb begin
    rdata_d = rdata_q;
    if (acc_i.rd) rdata_d = acc_i.mem ? mem_q[midx] : port_q[pidx];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  always_comb rdata_o = rdata_q;

  assert_port_write_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_i.wr && !acc_i.mem) |=> port_q[$past(pidx)] == $past(acc_i.data));
endmodule

// File: rtl/isa_slave_decoder.sv
module isa_slave_decoder
  import isa_dec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MEM_WORDS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aen,
  input  logic [ADDR_W-1:0] sa,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic              mem_en,
  input  logic [15:0]       io_base,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [15:0]       wr_data,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              is_mem,
  output logic [2:0]        port_idx,
  output logic              byte_lane,
  output logic [11:0]       mem_off,
  output logic              cmd_err,
  output logic [15:0]       rd_data
);
  logic [1:0]      rst_pipe_q;
  logic            rst_ni;
  logic [NCMD-1:0] cmd_n, lvl_n, fall;
  logic            io_hit, mem_hit;
  acc_t            acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  always_comb rst_ni = rst_pipe_q[1];

  always_comb begin
    cmd_n          = '1;
    cmd_n[C_IOR]   = ior_n;
    cmd_n[C_IOW]   = iow_n;
    cmd_n[C_MEMR]  = memr_n;
    cmd_n[C_MEMW]  = memw_n;
  end

  isa_cmd_sync #(.WIDTH(NCMD), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .cmd_n_i(cmd_n), .lvl_n_o(lvl_n), .fall_o(fall)
  );

  isa_win_match #(.ADDR_W(ADDR_W)) u_match (
    .aen_i(aen), .sa_i(sa), .mem_en_i(mem_en), .io_base_i(io_base),
    .mem_base_i(mem_base), .io_hit_o(io_hit), .mem_hit_o(mem_hit)
  );

  isa_acc_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_ni(rst_ni), .lvl_n_i(lvl_n), .fall_i(fall),
    .io_hit_i(io_hit), .mem_hit_i(mem_hit), .sa_i(sa), .wdata_i(wr_data),
    .acc_o(acc)
  );

  isa_reg_stub #(.MEM_WORDS(MEM_WORDS)) u_stub (
    .clk(clk), .rst_ni(rst_ni), .acc_i(acc), .rdata_o(rd_data)
  );

  always_comb begin
    rd_stb    = acc.rd;
    wr_stb    = acc.wr;
    is_mem    = acc.mem;
    port_idx  = acc.off[3:1];
    byte_lane = acc.off[0];
    mem_off   = acc.off;
    cmd_err   = acc.err;
  end

  assert_mem_gate_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((rd_stb || wr_stb) && is_mem) |-> $past(mem_en));
endmodule

// File: tb/isa_slave_decoder_tb.sv
module isa_slave_decoder_tb_top;
  localparam int unsigned AW = 20;
  localparam logic [15:0]   IOB = 16'h030A;
  localparam logic [AW-1:0] MEMB = 20'hD0000;

  logic clk = 1'b0;
  logic rst_n;
  logic aen, ior_n, iow_n, memr_n, memw_n, mem_en;
  logic [AW-1:0] sa;
  logic [15:0] io_base, wr_data, rd_data;
  logic [AW-1:0] mem_base;
  logic rd_stb, wr_stb, is_mem, byte_lane, cmd_err;
  logic [2:0] port_idx;
  logic [11:0] mem_off;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [15:0] m_port [8];
  logic [15:0] m_mem [16];

  always #5 clk = ~clk;

  isa_slave_decoder #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .aen(aen), .sa(sa), .ior_n(ior_n), .iow_n(iow_n),
    .memr_n(memr_n), .memw_n(memw_n), .mem_en(mem_en), .io_base(io_base),
    .mem_base(mem_base), .wr_data(wr_data), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .is_mem(is_mem), .port_idx(port_idx), .byte_lane(byte_lane),
    .mem_off(mem_off), .cmd_err(cmd_err), .rd_data(rd_data)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int cmd, input logic [AW-1:0] a,
                                 input logic e, input logic men);
    if (cmd < 2) return (e == 1'b0) && (a[15:4] == IOB[15:4]);
    return men && (a[AW-1:12] == MEMB[AW-1:12]);
  endfunction

  // cmd: 0 io read, 1 io write, 2 mem read, 3 mem write, 4 io conflict, 5 mem conflict
  task automatic access(input int cmd, input logic [AW-1:0] a, input logic e,
                        input logic men, input logic [15:0] d, input int hold);
    int nrd = 0, nwr = 0, nerr = 0, lat = -1;
    logic sm = 1'b0, sl = 1'b0;
    logic [2:0] sp = '0;
    logic [11:0] so = '0;
    bit hit, conf;
    int base;
    conf = (cmd >= 4);
    base = (cmd == 4) ? 0 : (cmd == 5) ? 2 : cmd;
    hit  = exp_hit(base, a, e, men);
    @(negedge clk);
    sa = a; aen = e; mem_en = men; wr_data = d;
    @(negedge clk);
    case (cmd)
      0: ior_n = 1'b0;
      1: iow_n = 1'b0;
      2: memr_n = 1'b0;
      3: memw_n = 1'b0;
      4: begin ior_n = 1'b0; iow_n = 1'b0; end
      default: begin memr_n = 1'b0; memw_n = 1'b0; end
    endcase
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (rd_stb || wr_stb) begin
        if (lat < 0) begin lat = k; sm = is_mem; sp = port_idx; sl = byte_lane; so = mem_off; end
        nrd += int'(rd_stb); nwr += int'(wr_stb);
      end
      nerr += int'(cmd_err);
    end
    ior_n = 1'b1; iow_n = 1'b1; memr_n = 1'b1; memw_n = 1'b1;
    repeat (4) @(negedge clk);
    if (conf) begin
      chk("R8 no strobe on conflict", (nrd + nwr) == 0, nrd + nwr, 0);
      chk("R8 err pulse count", nerr == (hit ? 1 : 0), nerr, hit ? 1 : 0);
    end else if (!hit) begin
      chk("R3/R4/R7 no strobe outside window", (nrd + nwr) == 0, nrd + nwr, 0);
    end else begin
      chk("R9 one strobe per command", (nrd == ((cmd % 2 == 0) ? 1 : 0)) &&
          (nwr == ((cmd % 2 == 1) ? 1 : 0)), nrd * 16 + nwr, (cmd % 2 == 0) ? 16 : 1);
      chk("R1/R2/R6 latency", lat == 3, lat, 3);
      chk("R1/R6 is_mem", sm == (cmd >= 2), int'(sm), int'(cmd >= 2));
      if (cmd < 2) begin
        chk("R1 port_idx", sp == a[3:1], int'(sp), int'(a[3:1]));
        chk("R1 byte_lane", sl == a[0], int'(sl), int'(a[0]));
      end else begin
        chk("R6 mem_off", so == a[11:0], int'(so), int'(a[11:0]));
      end
      if (cmd == 1) m_port[a[3:1]] = d;
      if (cmd == 3) m_mem[a[4:1]] = d;
      if (cmd == 0) chk("R11 io read data", rd_data == m_port[a[3:1]], int'(rd_data), int'(m_port[a[3:1]]));
      if (cmd == 2) chk("R11 mem read data", rd_data == m_mem[a[4:1]], int'(rd_data), int'(m_mem[a[4:1]]));
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < 8; i++) m_port[i] = '0;
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    rst_n = 1'b0; aen = 1'b0; sa = '0; ior_n = 1'b1; iow_n = 1'b1;
    memr_n = 1'b1; memw_n = 1'b1; mem_en = 1'b0; io_base = IOB;
    mem_base = MEMB; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {rd_stb, wr_stb, is_mem, cmd_err} == 4'b0, int'({rd_stb, wr_stb, is_mem, cmd_err}), 0);
    chk("R10 reset fields", port_idx == 3'd0 && mem_off == 12'd0 && rd_data == 16'd0, int'(mem_off), 0);
    // R5 I/O works with mem_en low straight after reset
    access(1, 20'h00306, 1'b0, 1'b0, 16'hA5C3, 6);
    access(0, 20'h00306, 1'b0, 1'b0, 16'h0000, 6);
    access(0, 20'h0030F, 1'b0, 1'b1, 16'h0000, 6);        // R5 with mem_en high, odd lane
    access(1, 20'h00302, 1'b1, 1'b0, 16'hFFFF, 6);        // R3 aen high
    access(0, 20'h00302, 1'b0, 1'b0, 16'h0000, 6);        // R3 port 1 untouched
    access(1, 20'h00312, 1'b0, 1'b0, 16'h1111, 6);        // R4 just above window
    access(1, 20'h002FE, 1'b0, 1'b0, 16'h2222, 6);        // R4 just below window
    access(1, 20'h10300, 1'b0, 1'b0, 16'h3C3C, 6);        // R4 upper SA bits above 15 ignored
    access(3, 20'hD0FFE, 1'b1, 1'b1, 16'hBEEF, 6);        // R6 top of window, aen high
    access(2, 20'hD0FFE, 1'b0, 1'b1, 16'h0000, 6);
    access(3, 20'hD0010, 1'b0, 1'b0, 16'h7777, 6);        // R7 disabled
    access(2, 20'hD0010, 1'b0, 1'b1, 16'h0000, 6);        // R7 word still zero
    access(2, 20'hD1000, 1'b0, 1'b1, 16'h0000, 6);        // R6 next 4K block
    access(4, 20'h00300, 1'b0, 1'b0, 16'h4444, 6);        // R8 io conflict
    access(0, 20'h00300, 1'b0, 1'b0, 16'h0000, 6);        // R8 port 0 untouched
    access(5, 20'hD0020, 1'b0, 1'b1, 16'h5555, 6);        // R8 mem conflict
    access(0, 20'h00304, 1'b0, 1'b0, 16'h0000, 40);       // R9 long hold
    access(3, 20'hD0002, 1'b0, 1'b1, 16'h9999, 40);       // R9 long hold write
    for (int n = 0; n < 300; n++) begin
      int c;
      logic [AW-1:0] a;
      c = int'($urandom_range(0, 5));
      a = AW'($urandom);
      case ($urandom_range(0, 2))
        0: a = {4'h0, IOB[15:4], a[3:0]};
        1: a = {MEMB[AW-1:12], a[11:0]};
        default: ;
      endcase
      access(c, a, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0),
             16'($urandom), 6);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule